// File: doc/BRIEF.md
# Peripheral Bus Clock Gating Controller

This block decides, one peripheral at a time, whether that peripheral receives the bus clock. Software sets or clears one enable bit per peripheral. The bits are spread across a small bank of 8-bit control registers; with the default of fourteen peripherals, two registers are used. Every enable bit is set when reset is released, so all peripherals start with a running clock. Clearing a bit stops the clock to that peripheral, which cuts its switching current during run and wait periods.

Each peripheral gets two clock forms. One is a gated clock produced by a cell that changes state on the falling edge, so no pulse is ever cut short. The other is a registered clock-enable, for peripherals that run from the free clock and qualify their flops with it. The block also sits on the peripheral select path. A write aimed at a peripheral whose clock is off never reaches it. A read from such a peripheral returns zero in the same cycle and does not hold up the bus. The control registers always run from the free clock, so software can switch a peripheral back on at any time.

Top module: `periph_clk_gate`

## Requirements
- R1: After reset every present peripheral enable is 1. With 14 peripherals, control register 0 reads 0xFF, register 1 reads 0x3F, and every gated clock runs.
- R2: A write with `ctl_sel`=1 and `bus_wr`=1 stores `bus_wdata` into control register `ctl_idx`. Bit i of register k controls peripheral 8k+i. `periph_clk_en` shows the new value from the clock edge that performs the write.
- R3: Bit positions of peripherals at or above NUM_PERIPH read as 0, and writes to them are ignored.
- R4: While its enable is 1, `periph_clk[p]` follows `clk`. While its enable is 0, it is held low.
- R5: An enable change reaches the gated clock only on a falling edge of `clk`. The high phase that starts at the write edge still carries the old enable. The next high phase carries the new one. No partial pulse is produced.
- R6: `periph_wr_en[p]` is 1 only when all four hold: `bus_wr`=1, `periph_sel[p]`=1, peripheral p is enabled, and `ctl_sel`=0. A write to a gated peripheral is dropped.
- R7: With `ctl_sel`=1, `bus_rdata` shows control register `ctl_idx`. Otherwise it shows the byte of the selected peripheral if that peripheral is enabled, and 0 if it is gated or nothing is selected. The path is combinational, within the same cycle.
- R8: The control registers keep working when every peripheral is gated. A peripheral can be re-enabled from that state.
- R9: A bus write with `ctl_sel`=0 leaves the control registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_sel | input | 1 | Bus access targets the gating control registers |
| ctl_idx | input | IDX_W (1) | Control register index |
| bus_wr | input | 1 | Bus write strobe |
| bus_wdata | input | 8 | Bus write data |
| bus_rdata | output | 8 | Bus read data (control register or filtered peripheral byte) |
| periph_sel | input | NUM_PERIPH | One-hot peripheral select from the address decoder |
| periph_rdata | input | NUM_PERIPH*8 | Read bytes from the peripherals, peripheral p at bits 8p+7:8p |
| periph_wr_en | output | NUM_PERIPH | Qualified write strobe per peripheral |
| periph_clk | output | NUM_PERIPH | Gated clock per peripheral |
| periph_clk_en | output | NUM_PERIPH | Registered clock-enable per peripheral |

## Verification
The hardest case to reach is the pulse right at the gating boundary. The high phase that begins at the very edge that writes a control register must still carry the old enable, and only the following high phase may carry the new one. The stimulus writes every 8-bit value into each control register. At each write it samples the gated clocks in the middle of the high phase at the write edge and again one cycle later, and checks them against the previous and the new enable vectors. Between writes, every peripheral is selected in turn for a write and a read, so the blocking of writes and the zeroing of reads are checked under every enable pattern.

// File: rtl/pcg_pkg.sv
`timescale 1ns/1ps
package pcg_pkg;

    // Width of one gating control register.
    localparam int PCG_REG_W = 8;

    // Source of the bus read data.
    typedef enum logic [1:0] {
        SRC_NONE   = 2'd0,
        SRC_CTL    = 2'd1,
        SRC_PERIPH = 2'd2
    } rd_src_e;

endpackage

// File: rtl/pcg_ctrl_regs.sv
`timescale 1ns/1ps
module pcg_ctrl_regs #(
    parameter int NUM_PERIPH = 14,
    parameter int REG_W      = pcg_pkg::PCG_REG_W,
    parameter int NUM_REGS   = (NUM_PERIPH + REG_W - 1) / REG_W,
    parameter int IDX_W      = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_i,
    input  logic [IDX_W-1:0]      idx_i,
    input  logic [REG_W-1:0]      wdata_i,
    output logic [REG_W-1:0]      rdata_o,
    output logic [NUM_PERIPH-1:0] en_o
);

    localparam int TOTAL_W = NUM_REGS * REG_W;
    localparam logic [TOTAL_W:0]   ONE_SH  = (TOTAL_W+1)'(1) << NUM_PERIPH;
    localparam logic [TOTAL_W-1:0] PRESENT = TOTAL_W'(ONE_SH - 1'b1);

    typedef struct packed {
        logic [TOTAL_W-1:0] en;
    } ctl_state_t;

    ctl_state_t st_d, st_q;
    logic       idx_ok;

    assign idx_ok = (int'(idx_i) < NUM_REGS);

    always_comb begin
        st_d = st_q;
        if (wr_i && idx_ok) begin
            st_d.en[int'(idx_i)*REG_W +: REG_W] =
                wdata_i & PRESENT[int'(idx_i)*REG_W +: REG_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.en <= PRESENT;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rdata_o = '0;
        if (idx_ok) begin
            rdata_o = st_q.en[int'(idx_i)*REG_W +: REG_W];
        end
    end

    assign en_o = st_q.en[NUM_PERIPH-1:0];

    for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg_chk
        // R2
        wr_apply_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_i && int'(idx_i) == r) |=>
            (st_q.en[r*REG_W +: REG_W] == ($past(wdata_i) & PRESENT[r*REG_W +: REG_W])));
    end

    // R9
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_i |=> $stable(st_q.en));

    // R3
    unused_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> ((st_q.en & ~PRESENT) == '0));

endmodule

// File: rtl/pcg_gate_cell.sv
`timescale 1ns/1ps
module pcg_gate_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    output logic gclk_o
);

    logic en_lat_q;

    // Enable is captured on the falling edge, so it is steady for the whole high phase.
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_lat_q <= 1'b1;
        end else begin
            en_lat_q <= en_i;
        end
    end

    assign gclk_o = clk & en_lat_q;

    // R5
    always @(en_lat_q) begin
        if (rst_n) begin
            glitch_free_chk: assert (clk == 1'b0);
        end
    end

    // R4
    lat_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en_lat_q == en_i);

endmodule

// File: rtl/pcg_access_filter.sv
`timescale 1ns/1ps
module pcg_access_filter #(
    parameter int NUM_PERIPH = 14,
    parameter int DW         = pcg_pkg::PCG_REG_W
) (
    input  logic                     ctl_sel_i,
    input  logic                     bus_wr_i,
    input  logic [NUM_PERIPH-1:0]    sel_i,
    input  logic [NUM_PERIPH-1:0]    en_i,
    input  logic [NUM_PERIPH*DW-1:0] prdata_i,
    input  logic [DW-1:0]            ctl_rdata_i,
    output logic [NUM_PERIPH-1:0]    wr_en_o,
    output logic [DW-1:0]            rdata_o
);

    import pcg_pkg::*;

    logic [NUM_PERIPH-1:0] live_sel;
    logic [DW-1:0]         periph_or;
    rd_src_e               src;

    assign live_sel = sel_i & en_i;
    assign wr_en_o  = (bus_wr_i && !ctl_sel_i) ? live_sel : '0;

    always_comb begin
        periph_or = '0;
        for (int p = 0; p < NUM_PERIPH; p++) begin
            if (live_sel[p]) begin
                periph_or = periph_or | prdata_i[p*DW +: DW];
            end
        end
    end

    always_comb begin
        if (ctl_sel_i) begin
            src = SRC_CTL;
        end else if (|live_sel) begin
            src = SRC_PERIPH;
        end else begin
            src = SRC_NONE;
        end
    end

    always_comb begin
        case (src)
            SRC_CTL:    rdata_o = ctl_rdata_i;
            SRC_PERIPH: rdata_o = periph_or;
            default:    rdata_o = '0;
        endcase
    end

endmodule

// File: rtl/periph_clk_gate.sv
`timescale 1ns/1ps
module periph_clk_gate #(
    parameter int NUM_PERIPH = 14,
    parameter int REG_W      = pcg_pkg::PCG_REG_W,
    parameter int NUM_REGS   = (NUM_PERIPH + REG_W - 1) / REG_W,
    parameter int IDX_W      = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        ctl_sel,
    input  logic [IDX_W-1:0]            ctl_idx,
    input  logic                        bus_wr,
    input  logic [REG_W-1:0]            bus_wdata,
    output logic [REG_W-1:0]            bus_rdata,
    input  logic [NUM_PERIPH-1:0]       periph_sel,
    input  logic [NUM_PERIPH*REG_W-1:0] periph_rdata,
    output logic [NUM_PERIPH-1:0]       periph_wr_en,
    output logic [NUM_PERIPH-1:0]       periph_clk,
    output logic [NUM_PERIPH-1:0]       periph_clk_en
);

    logic [REG_W-1:0] ctl_rdata;
    logic             ctl_wr;

    assign ctl_wr = ctl_sel & bus_wr;

    pcg_ctrl_regs #(
        .NUM_PERIPH (NUM_PERIPH),
        .REG_W      (REG_W),
        .NUM_REGS   (NUM_REGS),
        .IDX_W      (IDX_W)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (ctl_wr),
        .idx_i   (ctl_idx),
        .wdata_i (bus_wdata),
        .rdata_o (ctl_rdata),
        .en_o    (periph_clk_en)
    );

    for (genvar p = 0; p < NUM_PERIPH; p++) begin : g_gate
        pcg_gate_cell u_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .en_i   (periph_clk_en[p]),
            .gclk_o (periph_clk[p])
        );
    end

    pcg_access_filter #(
        .NUM_PERIPH (NUM_PERIPH),
        .DW         (REG_W)
    ) u_filter (
        .ctl_sel_i   (ctl_sel),
        .bus_wr_i    (bus_wr),
        .sel_i       (periph_sel),
        .en_i        (periph_clk_en),
        .prdata_i    (periph_rdata),
        .ctl_rdata_i (ctl_rdata),
        .wr_en_o     (periph_wr_en),
        .rdata_o     (bus_rdata)
    );

    // R1
    reset_all_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (periph_clk_en == '1));

    // R6
    gated_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (periph_wr_en & ~periph_clk_en) == '0);

    // R7
    gated_rd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_sel && $onehot(periph_sel) && ((periph_sel & periph_clk_en) == '0))
        |-> (bus_rdata == '0));

endmodule

// File: tb/periph_clk_gate_tb.sv
`timescale 1ns/1ps
module periph_clk_gate_tb;

    localparam int N = 14;
    localparam logic [15:0] MASK = 16'h3FFF;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         ctl_sel = 1'b0;
    logic [0:0]   ctl_idx = 1'b0;
    logic         bus_wr = 1'b0;
    logic [7:0]   bus_wdata = '0;
    logic [7:0]   bus_rdata;
    logic [N-1:0] periph_sel = '0;
    logic [N*8-1:0] periph_rdata = '0;
    logic [N-1:0] periph_wr_en;
    logic [N-1:0] periph_clk;
    logic [N-1:0] periph_clk_en;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;
    logic [15:0] exp_en = MASK;

    always #10 clk = ~clk;

    periph_clk_gate u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .ctl_sel       (ctl_sel),
        .ctl_idx       (ctl_idx),
        .bus_wr        (bus_wr),
        .bus_wdata     (bus_wdata),
        .bus_rdata     (bus_rdata),
        .periph_sel    (periph_sel),
        .periph_rdata  (periph_rdata),
        .periph_wr_en  (periph_wr_en),
        .periph_clk    (periph_clk),
        .periph_clk_en (periph_clk_en)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] pbyte(input int p, input logic [7:0] salt);
        return 8'((p * 29 + 8'h41)) ^ salt;
    endfunction

    task automatic ctl_read(input int idx, input string req);
        @(negedge clk);
        ctl_sel = 1'b1; bus_wr = 1'b0; ctl_idx = 1'(idx); periph_sel = '0;
        #2;
        chk(req, 32'(bus_rdata), 32'(exp_en[idx*8 +: 8]));
        ctl_sel = 1'b0;
    endtask

    task automatic ctl_write(input int idx, input logic [7:0] d, input string req);
        logic [15:0] old_en;
        old_en = exp_en;
        @(negedge clk);
        ctl_sel = 1'b1; bus_wr = 1'b1; ctl_idx = 1'(idx); bus_wdata = d;
        periph_sel = '1;
        #2;
        // R6: control access blocks peripheral writes
        chk("R6 ctl-priority", 32'(periph_wr_en), 32'd0);
        @(posedge clk); #5;
        exp_en[idx*8 +: 8] = d;
        exp_en = exp_en & MASK;
        chk(req, 32'(periph_clk_en), 32'(exp_en[N-1:0]));
        // R5: pulse at the write edge keeps the old enable
        chk("R5 old-phase", 32'(periph_clk), 32'(old_en[N-1:0]));
        @(negedge clk);
        ctl_sel = 1'b0; bus_wr = 1'b0; periph_sel = '0;
        #2;
        // R4: low phase holds every gated clock low
        chk("R4 low-phase", 32'(periph_clk), 32'd0);
        @(posedge clk); #5;
        // R5 / R4: next high phase carries the new enable
        chk("R5 new-phase", 32'(periph_clk), 32'(exp_en[N-1:0]));
    endtask

    task automatic periph_sweep(input logic [7:0] salt);
        for (int p = 0; p < N; p++) begin
            periph_rdata[p*8 +: 8] = pbyte(p, salt);
        end
        for (int p = 0; p < N; p++) begin
            @(negedge clk);
            ctl_sel = 1'b0; bus_wr = 1'b1; periph_sel = N'(1) << p;
            #2;
            chk("R6 wr-qualify", 32'(periph_wr_en), exp_en[p] ? 32'(N'(1) << p) : 32'd0);
            chk("R7 rd-filter", 32'(bus_rdata), exp_en[p] ? 32'(pbyte(p, salt)) : 32'd0);
        end
        @(negedge clk);
        bus_wr = 1'b0; periph_sel = '0;
        #2;
        chk("R7 no-select", 32'(bus_rdata), 32'd0);
        // R9: peripheral writes left the control state alone
        chk("R9 ctl-unchanged", 32'(periph_clk_en), 32'(exp_en[N-1:0]));
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #2;
        chk("R1 reset-en", 32'(periph_clk_en), 32'(MASK[N-1:0]));
        @(posedge clk); #5;
        chk("R1 clocks-run", 32'(periph_clk), 32'(MASK[N-1:0]));
        ctl_read(0, "R1 reg0");
        ctl_read(1, "R1 reg1");
        periph_sweep(8'h00);

        ctl_write(1, 8'hFF, "R3 unused-bits");
        ctl_read(1, "R3 unused-read");

        ctl_write(0, 8'h00, "R8 all-off0");
        ctl_write(1, 8'h00, "R8 all-off1");
        periph_sweep(8'h5C);
        ctl_write(0, 8'h5A, "R8 re-enable");
        ctl_read(0, "R8 readback");

        for (int d = 0; d < 256; d++) begin
            ctl_write(0, 8'(d), "R2 reg0");
            ctl_write(1, 8'(255 - d), "R2 reg1");
            ctl_read(0, "R2 read0");
            ctl_read(1, "R3 read1");
            periph_sweep(8'(d));
        end

        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog act=timeout exp=finish");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

endmodule